// File: doc/BRIEF.md
# Asynchronous Serial Transmitter

This block turns one data word at a time into an asynchronous serial frame on a single output line. A word is written into a holding register with a one-cycle load strobe; while the transmitter is enabled and a word is waiting, the block sends a low start bit, the data bits least significant first, an optional parity bit, and one or two high stop bits. Each bit lasts a whole number of clock cycles, derived from a divisor and an oversampling selection.

Two status outputs tell the producer where the block stands. The empty flag drops when a word is loaded and rises again when its frame has ended. The complete flag drops when a frame begins and rises in the same cycle as the empty flag. Word length, parity, stop count and bit period are sampled only at the start of each frame. A setting with an unsupported code is discarded as a whole, and the last accepted setting stays in force.

Top module: `serial_tx_engine`

## Requirements
- R1: After reset, `txd`, `tx_empty` and `tx_done` are all 1.
- R2: The line idles at 1 and no frame is in progress while `tx_empty` is 1. A frame is a 0 start bit, then the data bits least significant first, then the stop bits at 1.
- R3: The word length code `wlen_code` selects 8 data bits for 2'b00, 9 for 2'b01 and 7 for 2'b10. Bits of `load_data` above the selected length are not sent.
- R4: When `par_en` is 1, a parity bit follows the last data bit. With `par_odd` = 0 the data bits and the parity bit together hold an even number of ones. With `par_odd` = 1 they hold an odd number of ones.
- R5: The stop code `stop_code` = 2'b00 gives one stop bit and 2'b10 gives two.
- R6: With `over8` = 0, every bit lasts `baud_div` cycles. With `over8` = 1, every bit lasts ((`baud_div` & 16'hFFF0) | ((`baud_div` & 7) << 1)) / 2 cycles.
- R7: At a frame start, the whole set of inputs (word length, parity, stop count, bit period) is ignored if `stop_code` is 2'b01 or 2'b11, if `wlen_code` is 2'b11, or if `baud_div` is below 16. The last accepted set is then used. The set in force after reset is 8 data bits, no parity, one stop bit and a 16-cycle bit.
- R8: A `load` pulse while no frame is in progress stores `load_data`, and `tx_empty` reads 0 from the next cycle.
- R9: A frame starts only when `tx_en` is 1 and `tx_empty` is 0, and the start bit appears on `txd` one cycle later. Clearing `tx_en` during a frame does not cut that frame short.
- R10: `tx_done` drops when a frame starts. When the last stop bit has lasted its full period, `tx_empty` and `tx_done` both rise in the same cycle. That cycle is (1 + data + parity + stop bits) × period cycles after the start bit appeared.
- R11: While a frame is in progress, `load` and any configuration change have no effect on that frame. A load that arrives during a frame does not cause another frame to follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Transmitter enable, gates the start of a frame |
| wlen_code | input | 2 | Word length code |
| stop_code | input | 2 | Stop bit code |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | Parity sense: 1 odd, 0 even |
| over8 | input | 1 | Divisor interpreted for 8x oversampling |
| baud_div | input | DIV_W | Bit period divisor |
| load | input | 1 | One-cycle strobe that writes the holding register |
| load_data | input | DATA_W | Word to transmit |
| txd | output | 1 | Serial output line |
| tx_empty | output | 1 | No word waiting or in transmission |
| tx_done | output | 1 | Last frame finished |

## Verification
The assertions check the following on every cycle. The line is high whenever the block is empty. A frame only begins under an enable with a pending word, and it always opens with a low start bit. The complete flag stays low for the whole frame and rises together with the empty flag. A load into an empty block clears the empty flag on the next cycle. The bit values, word-length and parity decoding, stop-bit counts, exact bit periods under both oversampling modes, and the rejection of invalid settings are visible only in the bench's scenarios. There, each frame is decoded at the middle of every bit and its total length is measured.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int SX_MAX_DATA = 9;
  localparam int SX_FRAME_W  = SX_MAX_DATA + 3;
  localparam int SX_CNT_W    = $clog2(SX_FRAME_W + 1);

  typedef enum logic [1:0] {
    WL_EIGHT = 2'b00,
    WL_NINE  = 2'b01,
    WL_SEVEN = 2'b10,
    WL_BAD   = 2'b11
  } wlen_code_e;

  typedef enum logic [1:0] {
    SB_ONE     = 2'b00,
    SB_HALF    = 2'b01,
    SB_TWO     = 2'b10,
    SB_ONEHALF = 2'b11
  } stop_code_e;

  typedef struct packed {
    logic [SX_CNT_W-1:0] data_bits;
    logic                par_en;
    logic                par_odd;
    logic                two_stop;
  } frame_cfg_t;

  function automatic logic [SX_CNT_W-1:0] wlen_to_bits(input logic [1:0] code);
    case (code)
      WL_NINE:  return SX_CNT_W'(9);
      WL_SEVEN: return SX_CNT_W'(7);
      default:  return SX_CNT_W'(8);
    endcase
  endfunction

endpackage

// File: rtl/sertx_cfg_sel.sv
module sertx_cfg_sel
  import sertx_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int MIN_DIV   = 16,
  parameter int RESET_DIV = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             latch,
  input  logic [1:0]       wlen_code,
  input  logic [1:0]       stop_code,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             over8,
  input  logic [DIV_W-1:0] div_raw,
  output frame_cfg_t       nxt_cfg,
  output logic [DIV_W-1:0] nxt_period,
  output logic [DIV_W-1:0] run_period
);

  frame_cfg_t       held_cfg;
  logic [DIV_W-1:0] held_period;
  frame_cfg_t       cand_cfg;
  logic [DIV_W-1:0] cand_period;
  logic [DIV_W-1:0] folded;
  logic             stop_ok, wlen_ok, div_ok, all_ok;

  always_comb begin
    stop_ok = (stop_code == SB_ONE) || (stop_code == SB_TWO);
    wlen_ok = (wlen_code != WL_BAD);
    div_ok  = (div_raw >= DIV_W'(MIN_DIV));
    all_ok  = stop_ok && wlen_ok && div_ok;

    // 8x mode: low three bits carry half the fraction, bit 3 unused
    folded      = {div_raw[DIV_W-1:4], 4'b0000}
                | {{(DIV_W-4){1'b0}}, div_raw[2:0], 1'b0};
    cand_period = over8 ? (folded >> 1) : div_raw;

    cand_cfg.data_bits = wlen_to_bits(wlen_code);
    cand_cfg.par_en    = par_en;
    cand_cfg.par_odd   = par_odd;
    cand_cfg.two_stop  = stop_code[1];

    nxt_cfg    = all_ok ? cand_cfg    : held_cfg;
    nxt_period = all_ok ? cand_period : held_period;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_cfg.data_bits <= SX_CNT_W'(8);
      held_cfg.par_en    <= 1'b0;
      held_cfg.par_odd   <= 1'b0;
      held_cfg.two_stop  <= 1'b0;
      held_period        <= DIV_W'(RESET_DIV);
    end else if (latch) begin
      held_cfg    <= nxt_cfg;
      held_period <= nxt_period;
    end
  end

  assign run_period = held_period;

endmodule

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             active,
  input  logic [DIV_W-1:0] start_period,
  input  logic [DIV_W-1:0] run_period,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (restart) begin
      cnt <= start_period - DIV_W'(1);
    end else if (active) begin
      if (cnt == '0) cnt <= run_period - DIV_W'(1);
      else           cnt <= cnt - DIV_W'(1);
    end
  end

  assign tick = active && (cnt == '0);

endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
  import sertx_pkg::*;
#(
  parameter int DATA_W  = SX_MAX_DATA,
  parameter int FRAME_W = DATA_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              tick,
  input  frame_cfg_t        cfg,
  output logic              start,
  output logic              busy,
  output logic              txd,
  output logic              tx_empty,
  output logic              tx_done
);

  logic [DATA_W-1:0]   hold;
  logic [DATA_W-1:0]   mask;
  logic [FRAME_W-1:0]  fvec;
  logic [FRAME_W-1:0]  shreg;
  logic [SX_CNT_W-1:0] left;
  logic [SX_CNT_W-1:0] nbits;
  logic                par_bit;
  logic                load_ok;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = (SX_CNT_W'(i) < cfg.data_bits);
  end

  assign par_bit = (^(hold & mask)) ^ cfg.par_odd;

  // data bits, then parity in the slot after the last data bit, then ones
  for (genvar i = 0; i < FRAME_W; i++) begin : g_fvec
    if (i < DATA_W) begin : g_data
      assign fvec[i] = mask[i] ? hold[i]
                     : ((SX_CNT_W'(i) == cfg.data_bits) && cfg.par_en) ? par_bit
                     : 1'b1;
    end else begin : g_tail
      assign fvec[i] = ((SX_CNT_W'(i) == cfg.data_bits) && cfg.par_en) ? par_bit
                     : 1'b1;
    end
  end

  assign nbits = cfg.data_bits + SX_CNT_W'(cfg.par_en)
               + SX_CNT_W'(cfg.two_stop) + SX_CNT_W'(1);

  assign start   = tx_en && !tx_empty && !busy;
  assign load_ok = load && !busy && !start;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold     <= '0;
      tx_empty <= 1'b1;
      tx_done  <= 1'b1;
      busy     <= 1'b0;
      txd      <= 1'b1;
      shreg    <= '1;
      left     <= '0;
    end else begin
      if (start) begin
        busy    <= 1'b1;
        txd     <= 1'b0;
        tx_done <= 1'b0;
        shreg   <= fvec;
        left    <= nbits;
      end else if (busy && tick) begin
        if (left == '0) begin
          busy     <= 1'b0;
          txd      <= 1'b1;
          tx_empty <= 1'b1;
          tx_done  <= 1'b1;
        end else begin
          txd   <= shreg[0];
          shreg <= {1'b1, shreg[FRAME_W-1:1]};
          left  <= left - SX_CNT_W'(1);
        end
      end
      if (load_ok) begin
        hold     <= load_data;
        tx_empty <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/serial_tx_engine.sv
module serial_tx_engine
  import sertx_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int MIN_DIV   = 16,
  parameter int RESET_DIV = 16,
  parameter int DATA_W    = SX_MAX_DATA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic [1:0]        wlen_code,
  input  logic [1:0]        stop_code,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              over8,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              txd,
  output logic              tx_empty,
  output logic              tx_done
);

  localparam int FRAME_W = DATA_W + 3;

  frame_cfg_t       nxt_cfg;
  logic [DIV_W-1:0] nxt_period;
  logic [DIV_W-1:0] run_period;
  logic             frame_start;
  logic             frame_busy;
  logic             baud_tick;

  sertx_cfg_sel #(
    .DIV_W    (DIV_W),
    .MIN_DIV  (MIN_DIV),
    .RESET_DIV(RESET_DIV)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .latch     (frame_start),
    .wlen_code (wlen_code),
    .stop_code (stop_code),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .over8     (over8),
    .div_raw   (baud_div),
    .nxt_cfg   (nxt_cfg),
    .nxt_period(nxt_period),
    .run_period(run_period)
  );

  sertx_baud #(
    .DIV_W(DIV_W)
  ) u_baud (
    .clk         (clk),
    .rst         (rst),
    .restart     (frame_start),
    .active      (frame_busy),
    .start_period(nxt_period),
    .run_period  (run_period),
    .tick        (baud_tick)
  );

  sertx_frame #(
    .DATA_W (DATA_W),
    .FRAME_W(FRAME_W)
  ) u_frame (
    .clk      (clk),
    .rst      (rst),
    .tx_en    (tx_en),
    .load     (load),
    .load_data(load_data),
    .tick     (baud_tick),
    .cfg      (nxt_cfg),
    .start    (frame_start),
    .busy     (frame_busy),
    .txd      (txd),
    .tx_empty (tx_empty),
    .tx_done  (tx_done)
  );

endmodule

// File: rtl/serial_tx_engine_chk.sv
module serial_tx_engine_chk (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic load,
  input logic txd,
  input logic tx_empty,
  input logic tx_done,
  input logic busy
);

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> (txd && !busy));

  assert_start_bit_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !txd);

  assert_load_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (load && tx_empty) |=> !tx_empty);

  assert_start_gated_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(tx_en) && !$past(tx_empty)));

  assert_done_low_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !tx_done);

  assert_flags_pair_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_done) |-> (tx_empty && !busy && $rose(tx_empty)));

endmodule

bind serial_tx_engine serial_tx_engine_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .tx_en   (tx_en),
  .load    (load),
  .txd     (txd),
  .tx_empty(tx_empty),
  .tx_done (tx_done),
  .busy    (frame_busy)
);

// File: tb/serial_tx_engine_bench.sv
module serial_tx_engine_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_en = 1'b1;
  logic [1:0]  wlen_code = 2'b00;
  logic [1:0]  stop_code = 2'b00;
  logic        par_en = 1'b0;
  logic        par_odd = 1'b0;
  logic        over8 = 1'b0;
  logic [15:0] baud_div = 16'd16;
  logic        load = 1'b0;
  logic [8:0]  load_data = '0;
  logic        txd, tx_empty, tx_done;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  serial_tx_engine u_serial_tx_engine (
    .clk(clk), .rst(rst), .tx_en(tx_en), .wlen_code(wlen_code),
    .stop_code(stop_code), .par_en(par_en), .par_odd(par_odd),
    .over8(over8), .baud_div(baud_div), .load(load), .load_data(load_data),
    .txd(txd), .tx_empty(tx_empty), .tx_done(tx_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic set_cfg(input logic [1:0] wl, input logic [1:0] st,
                         input bit pe, input bit po, input bit o8,
                         input logic [15:0] dv);
    wlen_code = wl; stop_code = st; par_en = pe; par_odd = po;
    over8 = o8; baud_div = dv;
  endtask

  task automatic send_word(input logic [8:0] d);
    load_data = d;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk(tx_empty == 1'b0, "R8", "empty after load", tx_empty, 0);
  endtask

  task automatic step_to(inout int k, input int target,
                         input int poke_k, input int kind);
    while (k < target) begin
      if (k == poke_k && kind == 1) begin
        load = 1'b1; load_data = 9'h0F0; wlen_code = 2'b10; par_en = 1'b1;
      end else if (k == poke_k && kind == 2) begin
        tx_en = 1'b0;
      end else begin
        load = 1'b0;
      end
      @(negedge clk);
      k++;
    end
  endtask

  task automatic check_frame(input string req, input logic [8:0] d,
                             input int dbits, input bit pen, input bit podd,
                             input int nstop, input int per,
                             input int poke_k, input int kind);
    logic [15:0] expv;
    int total;
    int k;
    int guard;
    bit p;
    p = podd;
    expv = '1;
    expv[0] = 1'b0;
    for (int i = 0; i < dbits; i++) begin
      expv[1+i] = d[i];
      p ^= d[i];
    end
    total = 1 + dbits;
    if (pen) begin
      expv[total] = p;
      total++;
    end
    total += nstop;
    guard = 0;
    while (txd !== 1'b0 && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    chk(guard < 4000, "R9", "start bit appears", guard, 0);
    chk(tx_done == 1'b0, "R10", "done cleared at start", tx_done, 0);
    k = 0;
    for (int b = 0; b < total; b++) begin
      step_to(k, b * per + per / 2, poke_k, kind);
      chk(txd == expv[b], req, $sformatf("frame bit %0d", b), txd, expv[b]);
    end
    step_to(k, total * per - 1, poke_k, kind);
    chk(tx_done == 1'b0 && tx_empty == 1'b0, "R10", "flags before end",
        {tx_done, tx_empty}, 0);
    step_to(k, total * per, poke_k, kind);
    chk(tx_done == 1'b1 && tx_empty == 1'b1, "R10", "flags at end",
        {tx_done, tx_empty}, 3);
    load = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R1", "txd after reset", txd, 1);
    chk(tx_empty == 1'b1, "R1", "empty after reset", tx_empty, 1);
    chk(tx_done == 1'b1, "R1", "done after reset", tx_done, 1);
  endtask

  task automatic t_reset_cfg;
    set_cfg(2'b01, 2'b11, 1'b1, 1'b1, 1'b0, 16'd40);
    send_word(9'h1B4);
    check_frame("R7", 9'h1B4, 8, 0, 0, 1, 16, -1, 0);
  endtask

  task automatic t_plain;
    set_cfg(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 16'd24);
    send_word(9'h0A5);
    check_frame("R2", 9'h0A5, 8, 0, 0, 1, 24, -1, 0);
  endtask

  task automatic t_seven_even;
    set_cfg(2'b10, 2'b00, 1'b1, 1'b0, 1'b0, 16'd16);
    send_word(9'h1D3);
    check_frame("R3", 9'h1D3, 7, 1, 0, 1, 16, -1, 0);
  endtask

  task automatic t_nine_odd_two;
    set_cfg(2'b01, 2'b10, 1'b1, 1'b1, 1'b0, 16'd16);
    send_word(9'h1C3);
    check_frame("R5", 9'h1C3, 9, 1, 1, 2, 16, -1, 0);
    set_cfg(2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 16'd17);
    send_word(9'h007);
    check_frame("R4", 9'h007, 8, 1, 1, 1, 17, -1, 0);
  endtask

  task automatic t_over8;
    set_cfg(2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 16'h0025);
    send_word(9'h03C);
    check_frame("R6", 9'h03C, 8, 0, 0, 1, 21, -1, 0);
  endtask

  task automatic t_reject;
    set_cfg(2'b01, 2'b01, 1'b1, 1'b0, 1'b0, 16'd16);
    send_word(9'h155);
    check_frame("R7", 9'h155, 8, 0, 0, 1, 21, -1, 0);
    set_cfg(2'b11, 2'b10, 1'b1, 1'b0, 1'b0, 16'd16);
    send_word(9'h0E1);
    check_frame("R7", 9'h0E1, 8, 0, 0, 1, 21, -1, 0);
    set_cfg(2'b01, 2'b10, 1'b1, 1'b1, 1'b0, 16'd15);
    send_word(9'h12E);
    check_frame("R7", 9'h12E, 8, 0, 0, 1, 21, -1, 0);
  endtask

  task automatic t_disabled;
    int stray;
    set_cfg(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 16'd16);
    tx_en = 1'b0;
    send_word(9'h03C);
    stray = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (txd !== 1'b1 || tx_empty !== 1'b0) stray++;
    end
    chk(stray == 0, "R9", "idle while disabled", stray, 0);
    tx_en = 1'b1;
    check_frame("R9", 9'h03C, 8, 0, 0, 1, 16, -1, 0);
  endtask

  task automatic t_busy_ignore;
    int stray;
    set_cfg(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 16'd16);
    send_word(9'h00F);
    check_frame("R11", 9'h00F, 8, 0, 0, 1, 16, 40, 1);
    stray = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (txd !== 1'b1 || tx_empty !== 1'b1) stray++;
    end
    chk(stray == 0, "R11", "no frame from load during frame", stray, 0);
    set_cfg(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 16'd16);
  endtask

  task automatic t_enable_drop;
    send_word(9'h099);
    check_frame("R9", 9'h099, 8, 0, 0, 1, 16, 50, 2);
    tx_en = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_reset_cfg;
    t_plain;
    t_seven_even;
    t_nine_odd_two;
    t_over8;
    t_reject;
    t_disabled;
    t_busy_ignore;
    t_enable_drop;
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog R9 actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule